// File: doc/BRIEF.md
# Serial Control and Readout Port

This block is the host-facing control port of a digital audio receiver. A host drives a serial clock, an enable line and a data line. Each transfer begins with an 8-bit address byte, shifted in while the enable line is low. When the enable line rises, the address is decoded and the transfer switches to its data phase. Depending on the address, the data phase either collects an 8-bit command byte for the receiver or streams readout bits back to the host. A command byte is applied when the enable line falls again.

The port holds the receiver's command register and turns it into mode outputs: system stop, demodulator input choice, source of the auxiliary output pin, and audio output format. One static strap input picks between two framings. The framing sets both the address map and the way the readout pin is driven. The readout bits come from outside the block. The block only selects which stream to use and pulses an advance strobe for it.

All serial inputs are brought into the system clock domain through a synchronizer chain. Their edges are then detected in that domain.

Top module: `scp_serial_port`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it goes high, every command output is 0: `sys_stop`=0, `in_sel`=0, `aux_sel`=0, `out_fmt`=0.
- R2: Serial bits are taken on rising edges of `sck`, least significant bit first. Bits shifted while `sen` is low form the address, and the address is decoded when `sen` rises. Bits shifted while `sen` is high form the data phase, which ends when `sen` falls.
- R3: With `fmt_sel`=0, the address codes are 0xF7 for command write, 0xF8 for channel-status read and 0xF9 for subcode/ID read.
- R4: With `fmt_sel`=1, the address codes are 0xEA for command write, 0xE9 for channel-status read and 0xE8 for subcode/ID read. The codes of the other framing are unknown in this framing.
- R5: A command write takes effect when `sen` falls after at least 8 data bits, and the last 8 bits form the byte. Bit 1 drives `sys_stop` (1 = stopped) and bit 2 drives `in_sel` (0 = input 1, 1 = input 2).
- R6: Bits 3 and 4 set `aux_sel`: both 0 gives 0 (emphasis), bit3=1 with bit4=0 gives 1 (validity flag), bit3=0 with bit4=1 gives 2 (raw input 1), and both 1 gives 3 (raw input 2).
- R7: Bits 5 and 6 set `out_fmt`: both 0 gives 0 (16-bit right-justified, MSB first), bit5=1 with bit6=0 gives 1 (20-bit right-justified, MSB first), both 1 gives 2 (20-bit left-justified, MSB first), and bit5=0 with bit6=1 gives 3 (20-bit right-justified, LSB first).
- R8: Command bits 0 and 7 have no effect on any output.
- R9: An unknown address, an address with fewer than 8 bits, or a write with fewer than 8 data bits leaves the command outputs unchanged. The readout pin stays released (`sdo_oe`=0) outside a valid read data phase.
- R10: With `fmt_sel`=0, during a read the pin is open-drain: `sdo_val`=0, and `sdo_oe` is 1 exactly when the selected source bit is 0.
- R11: With `fmt_sel`=1, during a read the pin is driven: `sdo_oe`=1 and `sdo_val` equals the selected source bit.
- R12: In a read data phase, each `sck` rising edge produces one single-cycle pulse on the advance strobe of the addressed source (`cs_adv` for channel status, `sq_adv` for subcode). The other strobe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low mode/reset, asynchronous assert |
| fmt_sel | input | 1 | Framing strap: address map and readout drive style |
| sck | input | 1 | Serial clock from host |
| sen | input | 1 | Latch/enable line: low = address, high = data phase |
| sdi | input | 1 | Serial data from host |
| cs_bit | input | 1 | Current channel-status readout bit |
| sq_bit | input | 1 | Current subcode/ID readout bit |
| sdo_oe | output | 1 | Readout pin output enable |
| sdo_val | output | 1 | Readout pin value when enabled |
| cs_adv | output | 1 | Advance strobe to channel-status source |
| sq_adv | output | 1 | Advance strobe to subcode source |
| sys_stop | output | 1 | System stop |
| in_sel | output | 1 | Demodulator input select |
| aux_sel | output | 2 | Auxiliary pin source code |
| out_fmt | output | 2 | Audio output format code |

## Verification
Assertions check on every cycle that the command register changes only on a commit event. They also check that the register is clear on reset release, that the readout pin is released outside a read phase, that the tri-state framing always drives during a channel-status read, and that the advance strobes are mutually exclusive and tied to serial clock edges. The per-bit field decode, the two address maps, the rejection of short or unknown transfers and the exact readout values can only be shown by the bench's transfer scenarios. There, a behavioural model runs alongside the design and checks each of these every clock.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [1:0] {TGT_NONE, TGT_CMD, TGT_CS, TGT_SQ} tgt_e;
  typedef enum logic [1:0] {AUX_EMPH, AUX_VALID, AUX_RAW1, AUX_RAW2} aux_e;
  typedef enum logic [1:0] {FMT_R16, FMT_R20, FMT_L20, FMT_R20_LSB} afmt_e;

  // address byte to target; the two framings use disjoint maps
  function automatic tgt_e addr_to_tgt(input logic alt, input logic [BYTE_W-1:0] a);
    tgt_e t;
    t = TGT_NONE;
    if (!alt) begin
      case (a)
        8'hF7:   t = TGT_CMD;
        8'hF8:   t = TGT_CS;
        8'hF9:   t = TGT_SQ;
        default: t = TGT_NONE;
      endcase
    end else begin
      case (a)
        8'hEA:   t = TGT_CMD;
        8'hE9:   t = TGT_CS;
        8'hE8:   t = TGT_SQ;
        default: t = TGT_NONE;
      endcase
    end
    return t;
  endfunction

  function automatic aux_e aux_of(input logic b3, input logic b4);
    aux_e r;
    case ({b4, b3})
      2'b00:   r = AUX_EMPH;
      2'b01:   r = AUX_VALID;
      2'b10:   r = AUX_RAW1;
      default: r = AUX_RAW2;
    endcase
    return r;
  endfunction

  function automatic afmt_e fmt_of(input logic b5, input logic b6);
    afmt_e r;
    case ({b6, b5})
      2'b00:   r = FMT_R16;
      2'b01:   r = FMT_R20;
      2'b11:   r = FMT_L20;
      default: r = FMT_R20_LSB;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt,
  input  logic              sck_s,
  input  logic              sen_s,
  input  logic              sdi_s,
  output logic              sck_rise,
  output logic              data_phase,
  output tgt_e              tgt,
  output logic              commit,
  output logic [BYTE_W-1:0] byte_q
);
  logic             sck_d, sen_d;
  logic             sen_rise, sen_fall, full;
  logic [CNT_W-1:0] cnt;

  assign sck_rise = sck_s & ~sck_d;
  assign sen_rise = sen_s & ~sen_d;
  assign sen_fall = ~sen_s & sen_d;
  assign full     = (cnt == CNT_W'(BYTE_W));
  assign commit   = sen_fall & data_phase & (tgt == TGT_CMD) & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d      <= 1'b0;
      sen_d      <= 1'b0;
      byte_q     <= '0;
      cnt        <= '0;
      data_phase <= 1'b0;
      tgt        <= TGT_NONE;
    end else begin
      sck_d <= sck_s;
      sen_d <= sen_s;
      if (sen_rise) begin
        tgt        <= full ? addr_to_tgt(alt, byte_q) : TGT_NONE;
        data_phase <= 1'b1;
        cnt        <= '0;
      end else if (sen_fall) begin
        tgt        <= TGT_NONE;
        data_phase <= 1'b0;
        cnt        <= '0;
      end else if (sck_rise) begin
        byte_q <= {sdi_s, byte_q[BYTE_W-1:1]};
        if (!full) cnt <= cnt + 1'b1;
      end
    end
  end

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BYTE_W));
  a_r2_data_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise |=> data_phase);
  a_r9_idle_has_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |-> (tgt == TGT_NONE));
endmodule

// File: rtl/scp_cmdreg.sv
module scp_cmdreg
  import scp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [6:1] cmd_in,
  output logic       stop,
  output logic       sel,
  output aux_e       aux,
  output afmt_e      fmt
);
  logic [6:1] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (commit) cmd_q <= cmd_in;
  end

  assign stop = cmd_q[1];
  assign sel  = cmd_q[2];
  assign aux  = aux_of(cmd_q[3], cmd_q[4]);
  assign fmt  = fmt_of(cmd_q[5], cmd_q[6]);

  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cmd_q));
endmodule

// File: rtl/scp_readmux.sv
module scp_readmux
  import scp_pkg::*;
(
  input  logic alt,
  input  logic data_phase,
  input  tgt_e tgt,
  input  logic sck_rise,
  input  logic cs_bit,
  input  logic sq_bit,
  output logic sdo_oe,
  output logic sdo_val,
  output logic cs_adv,
  output logic sq_adv
);
  logic rd_cs, rd_sq, rd_on, src;

  assign rd_cs = data_phase & (tgt == TGT_CS);
  assign rd_sq = data_phase & (tgt == TGT_SQ);
  assign rd_on = rd_cs | rd_sq;
  assign src   = rd_cs ? cs_bit : sq_bit;

  always_comb begin
    if (alt) begin
      sdo_oe  = rd_on;
      sdo_val = rd_on & src;
    end else begin
      sdo_oe  = rd_on & ~src;
      sdo_val = 1'b0;
    end
  end

  assign cs_adv = rd_cs & sck_rise;
  assign sq_adv = rd_sq & sck_rise;
endmodule

// File: rtl/scp_serial_port.sv
module scp_serial_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fmt_sel,
  input  logic       sck,
  input  logic       sen,
  input  logic       sdi,
  input  logic       cs_bit,
  input  logic       sq_bit,
  output logic       sdo_oe,
  output logic       sdo_val,
  output logic       cs_adv,
  output logic       sq_adv,
  output logic       sys_stop,
  output logic       in_sel,
  output logic [1:0] aux_sel,
  output logic [1:0] out_fmt
);
  logic              sck_s, sen_s, sdi_s;
  logic              sck_rise, data_phase, commit;
  tgt_e              tgt;
  logic [BYTE_W-1:0] byte_q;
  aux_e              aux;
  afmt_e             fmt;

  scp_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (.clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
  scp_sync #(.STAGES(SYNC_STAGES)) u_sync_sen (.clk(clk), .rst_n(rst_n), .d(sen), .q(sen_s));
  scp_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (.clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

  scp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .alt(fmt_sel),
    .sck_s(sck_s), .sen_s(sen_s), .sdi_s(sdi_s),
    .sck_rise(sck_rise), .data_phase(data_phase), .tgt(tgt),
    .commit(commit), .byte_q(byte_q)
  );

  scp_cmdreg u_cmd (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cmd_in(byte_q[6:1]),
    .stop(sys_stop), .sel(in_sel), .aux(aux), .fmt(fmt)
  );

  scp_readmux u_rd (
    .alt(fmt_sel), .data_phase(data_phase), .tgt(tgt), .sck_rise(sck_rise),
    .cs_bit(cs_bit), .sq_bit(sq_bit),
    .sdo_oe(sdo_oe), .sdo_val(sdo_val), .cs_adv(cs_adv), .sq_adv(sq_adv)
  );

  assign aux_sel = aux;
  assign out_fmt = fmt;

  a_r1_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sys_stop && !in_sel && aux_sel == 2'd0 && out_fmt == 2'd0));
  a_r9_released_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |-> !sdo_oe);
  a_r11_tristate_drives_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel && data_phase && tgt == TGT_CS) |-> sdo_oe);
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_adv, sq_adv}));
  a_r12_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_adv || sq_adv) |-> (sck_rise && data_phase));
endmodule

// File: tb/test_scp_serial_port.sv
module test_scp_serial_port;
  logic clk = 1'b0, rst_n = 1'b0, fmt_sel = 1'b0;
  logic sck = 1'b0, sen = 1'b0, sdi = 1'b0, cs_bit = 1'b0, sq_bit = 1'b0;
  logic sdo_oe, sdo_val, cs_adv, sq_adv, sys_stop, in_sel;
  logic [1:0] aux_sel, out_fmt;

  int n_cmp = 0, n_bad = 0, n_cs = 0, n_sq = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scp_serial_port i_scp_serial_port (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sck(sck), .sen(sen), .sdi(sdi),
    .cs_bit(cs_bit), .sq_bit(sq_bit), .sdo_oe(sdo_oe), .sdo_val(sdo_val),
    .cs_adv(cs_adv), .sq_adv(sq_adv), .sys_stop(sys_stop), .in_sel(in_sel),
    .aux_sel(aux_sel), .out_fmt(out_fmt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // target codes: 0 none, 1 write, 2 channel status, 3 subcode
  function automatic int want_tgt(input bit alt, input int a);
    if (!alt) return (a == 'hF7) ? 1 : (a == 'hF8) ? 2 : (a == 'hF9) ? 3 : 0;
    return (a == 'hEA) ? 1 : (a == 'hE9) ? 2 : (a == 'hE8) ? 3 : 0;
  endfunction

  // packed {stop, sel, aux[1:0], fmt[1:0]} expected from a command byte
  function automatic int want_cmd(input int b);
    int b3, b4, b5, b6, aux, fmt;
    b3 = (b >> 3) & 1; b4 = (b >> 4) & 1; b5 = (b >> 5) & 1; b6 = (b >> 6) & 1;
    aux = b4 ? (b3 ? 3 : 2) : (b3 ? 1 : 0);
    fmt = b6 ? (b5 ? 2 : 3) : (b5 ? 1 : 0);
    return (((b >> 1) & 1) << 5) | (((b >> 2) & 1) << 4) | (aux << 2) | fmt;
  endfunction

  function automatic int got_cmd();
    return {26'd0, sys_stop, in_sel, aux_sel, out_fmt};
  endfunction

  // ---------------- behavioural reference model ----------------
  bit q_sck[$], q_sen[$], q_sdi[$];
  bit p_sck, p_sen, m_data;
  int m_sr, m_cnt, m_tgt, m_cmd;

  always @(posedge clk or negedge rst_n) begin
    bit s_ck, s_en, s_di, ev_r, ev_up, ev_dn;
    if (!rst_n) begin
      q_sck = '{1'b0, 1'b0}; q_sen = '{1'b0, 1'b0}; q_sdi = '{1'b0, 1'b0};
      p_sck = 0; p_sen = 0; m_data = 0; m_sr = 0; m_cnt = 0; m_tgt = 0; m_cmd = 0;
    end else begin
      s_ck = q_sck[0]; s_en = q_sen[0]; s_di = q_sdi[0];
      ev_r = s_ck && !p_sck; ev_up = s_en && !p_sen; ev_dn = !s_en && p_sen;
      if (ev_up) begin
        m_tgt = (m_cnt == 8) ? want_tgt(fmt_sel, m_sr) : 0;
        m_data = 1; m_cnt = 0;
      end else if (ev_dn) begin
        if (m_data && m_tgt == 1 && m_cnt == 8) m_cmd = m_sr;
        m_data = 0; m_tgt = 0; m_cnt = 0;
      end else if (ev_r) begin
        m_sr = (m_sr >> 1) | (int'(s_di) << 7);
        if (m_cnt < 8) m_cnt++;
      end
      p_sck = s_ck; p_sen = s_en;
      void'(q_sck.pop_front()); q_sck.push_back(sck);
      void'(q_sen.pop_front()); q_sen.push_back(sen);
      void'(q_sdi.pop_front()); q_sdi.push_back(sdi);
    end
  end

  always @(negedge clk) begin
    bit rise, rd, src, e_oe, e_val, e_cs, e_sq;
    if (!done) begin
      rise = q_sck[0] && !p_sck;
      rd = m_data && (m_tgt == 2 || m_tgt == 3);
      src = (m_tgt == 2) ? cs_bit : sq_bit;
      e_oe = fmt_sel ? rd : (rd && !src);
      e_val = fmt_sel ? (rd && src) : 1'b0;
      e_cs = rise && m_data && m_tgt == 2;
      e_sq = rise && m_data && m_tgt == 3;
      check(got_cmd() == want_cmd(m_cmd), "R5 R6 R7 model cmd", got_cmd(), want_cmd(m_cmd));
      check({sdo_oe, sdo_val} == {e_oe, e_val}, "R10 R11 model sdo",
            {sdo_oe, sdo_val}, {e_oe, e_val});
      check({cs_adv, sq_adv} == {e_cs, e_sq}, "R12 model strobe", {cs_adv, sq_adv}, {e_cs, e_sq});
      if (cs_adv) n_cs++;
      if (sq_adv) n_sq++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sbit(input bit b);
    sdi = b; tick(4);
    sck = 1'b1; tick(4);
    sck = 1'b0;
  endtask

  // rdm: 0 no pin check, 1 open-drain, 2 three-state, 3 released
  task automatic xfer(input int a, input int n, input int d, input int rdm, input string tag);
    sen = 1'b0; tick(4);
    for (int i = 0; i < 8; i++) sbit(a[i]);
    tick(4);
    sen = 1'b1; tick(6);
    for (int i = 0; i < n; i++) begin
      cs_bit = d[i]; sq_bit = d[i]; sdi = d[i];
      tick(4);
      if (rdm == 1) check(sdo_oe == !d[i] && sdo_val == 1'b0, tag, {sdo_oe, sdo_val}, {!d[i], 1'b0});
      if (rdm == 2) check(sdo_oe && sdo_val == d[i], tag, {sdo_oe, sdo_val}, {1'b1, d[i]});
      if (rdm == 3) check(!sdo_oe, tag, sdo_oe, 0);
      sck = 1'b1; tick(4);
      sck = 1'b0;
    end
    tick(4);
    sen = 1'b0; tick(8);
  endtask

  task automatic wr(input int a, input int d, input int exp_byte, input string tag);
    xfer(a, 8, d, 0, tag);
    check(got_cmd() == want_cmd(exp_byte), tag, got_cmd(), want_cmd(exp_byte));
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    tick(5);
    check(got_cmd() == 0 && !sdo_oe, "R1 during reset", got_cmd(), 0);
    rst_n = 1'b1; tick(3);
    check(got_cmd() == 0, "R1 after release", got_cmd(), 0);

    wr('hF7, 'h02, 'h02, "R2 R3 R5 stop via bit1");
    wr('hF7, 'h04, 'h04, "R5 input select bit2");
    wr('hF7, 'h08, 'h08, "R6 validity");
    wr('hF7, 'h10, 'h10, "R6 raw input 1");
    wr('hF7, 'h18, 'h18, "R6 raw input 2");
    wr('hF7, 'h20, 'h20, "R7 20-bit right MSB");
    wr('hF7, 'h60, 'h60, "R7 20-bit left");
    wr('hF7, 'h40, 'h40, "R7 20-bit right LSB");
    wr('hF7, 'h7E, 'h7E, "R5 R6 R7 all fields set");
    wr('hF7, 'h81, 'h00, "R8 bits 0 and 7 ignored");
    wr('hF7, 'h7E, 'h7E, "R5 restore");
    xfer('hF6, 8, 'hFF, 3, "R9 unknown address released");
    check(got_cmd() == want_cmd('h7E), "R9 unknown address no write", got_cmd(), want_cmd('h7E));
    xfer('hF7, 5, 'h00, 0, "R9 short data");
    check(got_cmd() == want_cmd('h7E), "R9 short data no write", got_cmd(), want_cmd('h7E));

    n_cs = 0; n_sq = 0;
    xfer('hF8, 8, 'hA5, 1, "R10 open-drain channel status");
    check(n_cs == 8 && n_sq == 0, "R12 channel status strobes", n_cs * 16 + n_sq, 128);
    n_cs = 0; n_sq = 0;
    xfer('hF9, 4, 'h06, 1, "R3 R10 open-drain subcode");
    check(n_sq == 4 && n_cs == 0, "R12 subcode strobes", n_sq * 16 + n_cs, 64);

    fmt_sel = 1'b1; tick(4);
    wr('hEA, 'h24, 'h24, "R4 alt write");
    wr('hF7, 'h02, 'h24, "R4 other map unknown");
    n_cs = 0; n_sq = 0;
    xfer('hE8, 8, 'h3C, 2, "R11 three-state subcode");
    check(n_sq == 8 && n_cs == 0, "R12 alt subcode strobes", n_sq * 16 + n_cs, 128);
    n_cs = 0; n_sq = 0;
    xfer('hE9, 6, 'h29, 2, "R11 three-state channel status");
    check(n_cs == 6 && n_sq == 0, "R12 alt channel status strobes", n_cs * 16 + n_sq, 96);

    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(3);
    check(got_cmd() == 0, "R1 mid-run reset clears", got_cmd(), 0);
    tick(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule